// File: doc/BRIEF.md
# Framed Packet Receiver with Address Filter

This block takes the byte stream coming out of a UART receiver and pulls complete, checked frames out of it. A frame opens and closes with a marker byte `0x7E`. Any `0x7E` or `0x7D` inside the frame is sent as the pair `0x7D, b ^ 0x20`, and the receiver turns that pair back into the original byte. The first byte after the opening marker is the destination address. If it does not equal `node_addr_i`, the block drops the frame at once and goes back to hunting for a marker. The frame is never buffered.

The last byte before the closing marker is an 8-bit checksum. It is the modulo-256 sum of the address byte and every payload byte. Payload bytes go out on a simple write port (index, data) as they are confirmed. The closing marker gives either a good-frame strobe with the payload length, or a bad-frame strobe. Two or more markers in a row form empty frames, which are dropped with no report, so a sender can use markers as a preamble.

A closing marker can also open the next frame. If a marker is lost, the next marker puts the block back in step. Oversized payloads and UART framing errors abort the frame. All outputs are registered, so each result appears on the clock cycle after the byte that caused it.

Top module: `frame_rx_filter`

## Requirements
- R1: After reset, every strobe, `wr_en_o` and `frame_len_o` are zero.
- R2: While hunting for a marker, each accepted byte other than `0x7E` pulses `err_diag_o` for one cycle. The block stays in the hunt state, even when that byte equals the node address.
- R3: A frame `7E, A, P0..Pn-1, C, 7E` with A equal to `node_addr_i` and C = (A + sum of P) mod 256 writes Pi at index i with one `wr_en_o` pulse per byte. In the cycle right after the closing marker it pulses `frame_ok_o`, with `frame_len_o` = n.
- R4: A frame whose address differs from `node_addr_i` causes no write and no `frame_ok_o`. The block returns to hunting, so the rest of that frame's bytes each raise `err_diag_o`.
- R5: A closing marker whose checksum byte does not match pulses `err_frame_o` and no `frame_ok_o`. This includes a frame with no byte after the address.
- R6: Inside a frame (address, payload and checksum), the pair `7D, b` stands for the byte `b ^ 0x20`. For example, `7D 5E` gives `7E` and `7D 5D` gives `7D`.
- R7: Back-to-back markers form empty frames, which raise no strobe. A following frame is received normally.
- R8: A marker that arrives before a frame is complete ends that frame, pulsing `err_frame_o` unless its checksum happens to match. The bytes that follow are taken as a new frame.
- R9: Up to DEPTH payload bytes are accepted. A frame with more pulses `err_ovr_o`, makes no more than DEPTH writes, gives no `frame_ok_o`, and returns to hunting.
- R10: A byte flagged with `rx_ferr_i` pulses `err_ferr_o`, aborts any frame in progress, and returns to hunting.
- R11: An escape byte directly followed by the closing marker makes the frame bad (`err_frame_o`), even when the byte before the escape is a correct checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | 8 | Address of this node |
| rx_vld_i | input | 1 | Received byte valid, one cycle per byte |
| rx_data_i | input | 8 | Received byte |
| rx_ferr_i | input | 1 | UART framing error on this byte |
| wr_en_o | output | 1 | Payload buffer write strobe |
| wr_addr_o | output | $clog2(DEPTH) | Payload buffer write index |
| wr_data_o | output | 8 | Payload byte, escape removed |
| frame_ok_o | output | 1 | Good frame strobe |
| frame_len_o | output | $clog2(DEPTH+1) | Payload length of the last good frame |
| err_diag_o | output | 1 | Stray byte seen while hunting |
| err_frame_o | output | 1 | Bad checksum, missing checksum or dangling escape |
| err_ovr_o | output | 1 | Payload exceeded DEPTH |
| err_ferr_o | output | 1 | UART framing error seen |

## Verification
The receive state can be seen at the ports on the very next byte. If the block wrongly thinks it is hunting, a stray `err_diag_o` pulse appears. If it wrongly thinks it is inside a frame, an expected pulse goes missing. A stuck escape flag shows up one cycle after the next byte, as a `wr_data_o` value XORed with `0x20`. A bad checksum seed or a miscounted length stays hidden until the closing marker, where the choice between `frame_ok_o` and `err_frame_o` and the value of `frame_len_o` expose it. The tests therefore pair each scenario with a follow-up frame, so that any state left behind by one case shows up in the next.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h7E;
  localparam logic [7:0] ESC_BYTE  = 8'h7D;
  localparam logic [7:0] ESC_FLIP  = 8'h20;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxf_destuff.sv
`timescale 1ns/1ps
module rxf_destuff
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       vld_i,
  input  logic [7:0] data_i,
  input  logic       ferr_i,
  output logic       sync_o,
  output logic       tok_vld_o,
  output logic [7:0] tok_o,
  output logic       esc_pend_o
);
  logic esc_q;
  logic is_esc;
  logic clean;

  always_comb begin
    clean      = vld_i && !ferr_i;
    sync_o     = clean && (data_i == SYNC_BYTE);
    is_esc     = clean && (data_i == ESC_BYTE) && !esc_q;
    tok_vld_o  = clean && !sync_o && !is_esc;
    tok_o      = esc_q ? (data_i ^ ESC_FLIP) : data_i;
    esc_pend_o = esc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      esc_q <= 1'b0;
    else if (clear_i) esc_q <= 1'b0;
    else if (vld_i)   esc_q <= is_esc;
  end

  // R6: an escape never survives the hunt state
  assert_esc_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> !esc_q);
endmodule

// File: rtl/rxf_payload.sv
`timescale 1ns/1ps
module rxf_payload #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    seed_i,
  input  logic          push_i,
  input  logic [7:0]    byte_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          ovr_o,
  output logic          good_o,
  output logic [CW-1:0] cnt_o
);
  logic          pend_vld_q;
  logic [7:0]    pend_q;
  logic [7:0]    sum_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en_q;
  logic [AW-1:0] wr_addr_q;
  logic [7:0]    wr_data_q;
  logic          full;

  // last byte stays pending: it may turn out to be the checksum
  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    ovr_o  = push_i && pend_vld_q && full;
    good_o = pend_vld_q && (pend_q == sum_q);
    cnt_o  = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      sum_q      <= '0;
      cnt_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        pend_vld_q <= 1'b0;
        sum_q      <= seed_i;
        cnt_q      <= '0;
      end else if (push_i) begin
        if (pend_vld_q && !full) begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= cnt_q[AW-1:0];
          wr_data_q <= pend_q;
          sum_q     <= sum_q + pend_q;
          cnt_q     <= cnt_q + 1'b1;
        end
        pend_q     <= byte_i;
        pend_vld_q <= 1'b1;
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  assert_write_follows_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> $past(push_i));

  always_comb begin
    if (rst_ni) assert_cnt_bound_R9: assert (cnt_q <= CW'(DEPTH));
  end
endmodule

// File: rtl/frame_rx_filter.sv
`timescale 1ns/1ps
module frame_rx_filter
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    node_addr_i,
  input  logic          rx_vld_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_ferr_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          frame_ok_o,
  output logic [CW-1:0] frame_len_o,
  output logic          err_diag_o,
  output logic          err_frame_o,
  output logic          err_ovr_o,
  output logic          err_ferr_o
);
  rx_state_e     st_q, st_d;
  logic          sync, tok_vld, esc_pend;
  logic [7:0]    tok;
  logic          start, push, ovr, good;
  logic [CW-1:0] cnt;
  logic          ok_d, bad_d, ovr_d, ferr_d, diag_d;
  logic          ok_q, bad_q, ovr_q, ferr_q, diag_q;
  logic [CW-1:0] len_q;
  logic          ferr_in;

  rxf_destuff u_destuff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_q == ST_HUNT),
    .vld_i      (rx_vld_i),
    .data_i     (rx_data_i),
    .ferr_i     (rx_ferr_i),
    .sync_o     (sync),
    .tok_vld_o  (tok_vld),
    .tok_o      (tok),
    .esc_pend_o (esc_pend)
  );

  rxf_payload #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_payload (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .seed_i    (tok),
    .push_i    (push),
    .byte_i    (tok),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .ovr_o     (ovr),
    .good_o    (good),
    .cnt_o     (cnt)
  );

  always_comb begin
    st_d    = st_q;
    start   = 1'b0;
    push    = 1'b0;
    ok_d    = 1'b0;
    bad_d   = 1'b0;
    ovr_d   = 1'b0;
    ferr_d  = 1'b0;
    diag_d  = 1'b0;
    ferr_in = rx_vld_i && rx_ferr_i;
    unique case (st_q)
      ST_HUNT: begin
        if (ferr_in)       ferr_d = 1'b1;
        else if (sync)     st_d   = ST_ADDR;
        else if (rx_vld_i) diag_d = 1'b1;
      end
      ST_ADDR: begin
        if (ferr_in) begin
          ferr_d = 1'b1;
          st_d   = ST_HUNT;
        end else if (tok_vld) begin
          if (tok == node_addr_i) begin
            start = 1'b1;
            st_d  = ST_DATA;
          end else begin
            st_d  = ST_HUNT;
          end
        end
      end
      ST_DATA: begin
        if (ferr_in) begin
          ferr_d = 1'b1;
          st_d   = ST_HUNT;
        end else if (sync) begin
          // closing marker doubles as next opener
          if (good && !esc_pend) ok_d  = 1'b1;
          else                   bad_d = 1'b1;
          st_d = ST_ADDR;
        end else if (tok_vld) begin
          push = 1'b1;
          if (ovr) begin
            ovr_d = 1'b1;
            st_d  = ST_HUNT;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
      diag_q <= 1'b0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      ok_q   <= ok_d;
      bad_q  <= bad_d;
      ovr_q  <= ovr_d;
      ferr_q <= ferr_d;
      diag_q <= diag_d;
      if (ok_d) len_q <= cnt;
    end
  end

  assign frame_ok_o  = ok_q;
  assign frame_len_o = len_q;
  assign err_diag_o  = diag_q;
  assign err_frame_o = bad_q;
  assign err_ovr_o   = ovr_q;
  assign err_ferr_o  = ferr_q;

  assert_strobes_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_q, bad_q, ovr_q, ferr_q, diag_q}));

  assert_ok_reopens_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> (st_q == ST_ADDR));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> (st_q == ST_HUNT && !wr_en_o));

  assert_ferr_hunts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |-> (st_q == ST_HUNT));

  assert_diag_keeps_hunt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_q |-> (st_q == ST_HUNT));

  assert_len_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> (frame_len_o <= CW'(DEPTH)));
endmodule

// File: tb/frame_rx_filter_bench.sv
`timescale 1ns/1ps
module frame_rx_filter_bench;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [7:0] NODE = 8'h05;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    node_addr_i = NODE;
  logic          rx_vld_i = 1'b0;
  logic [7:0]    rx_data_i = 8'h00;
  logic          rx_ferr_i = 1'b0;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0]    wr_data_o;
  logic          frame_ok_o;
  logic [CW-1:0] frame_len_o;
  logic          err_diag_o, err_frame_o, err_ovr_o, err_ferr_o;

  frame_rx_filter #(.DEPTH(DEPTH)) u_frame_rx_filter (
    .clk_i, .rst_ni, .node_addr_i, .rx_vld_i, .rx_data_i, .rx_ferr_i,
    .wr_en_o, .wr_addr_o, .wr_data_o, .frame_ok_o, .frame_len_o,
    .err_diag_o, .err_frame_o, .err_ovr_o, .err_ferr_o
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int n_wr, n_ok, n_bad, n_ovr, n_ferr, n_diag;
  logic [7:0] cap [DEPTH];
  logic [7:0] pl [32];

  always @(negedge clk_i) if (rst_ni) begin
    if (wr_en_o) begin cap[wr_addr_o] = wr_data_o; n_wr++; end
    if (frame_ok_o)  n_ok++;
    if (err_frame_o) n_bad++;
    if (err_ovr_o)   n_ovr++;
    if (err_ferr_o)  n_ferr++;
    if (err_diag_o)  n_diag++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_wr = 0; n_ok = 0; n_bad = 0; n_ovr = 0; n_ferr = 0; n_diag = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit fe = 1'b0);
    @(negedge clk_i);
    rx_vld_i = 1'b1; rx_data_i = b; rx_ferr_i = fe;
    @(negedge clk_i);
    rx_vld_i = 1'b0; rx_ferr_i = 1'b0;
  endtask

  task automatic send_st(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      send_byte(8'h7D);
      send_byte(b ^ 8'h20);
    end else send_byte(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // opens, sends address, payload and checksum (+delta), optional close
  task automatic send_frame(input logic [7:0] a, input int n, input logic [7:0] delta, input bit close);
    logic [7:0] ck = a;
    for (int i = 0; i < n; i++) ck += pl[i];
    send_byte(8'h7E);
    send_st(a);
    for (int i = 0; i < n; i++) send_st(pl[i]);
    send_st(ck + delta);
    if (close) send_byte(8'h7E);
  endtask

  task automatic t_reset();
    chk("R1 wr_en", wr_en_o, 0);
    chk("R1 strobes", {frame_ok_o, err_diag_o, err_frame_o, err_ovr_o, err_ferr_o}, 0);
    chk("R1 frame_len", frame_len_o, 0);
  endtask

  task automatic t_good();
    clr_mon();
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    send_frame(NODE, 3, 8'h00, 1'b0);
    idle(2);
    chk("R3 no ok before close", n_ok, 0);
    send_byte(8'h7E);
    chk("R3 ok next cycle", frame_ok_o, 1);
    chk("R3 len", frame_len_o, 3);
    idle(2);
    chk("R3 writes", n_wr, 3);
    chk("R3 data0", cap[0], 8'h11);
    chk("R3 data2", cap[2], 8'h33);
    chk("R3 single ok", n_ok, 1);
  endtask

  task automatic t_mismatch();
    clr_mon();
    pl[0] = 8'h11;
    send_frame(8'h09, 1, 8'h00, 1'b1);
    idle(2);
    chk("R4 no writes", n_wr, 0);
    chk("R4 no ok", n_ok, 0);
    chk("R4 diag on rest", n_diag, 2);
  endtask

  task automatic t_hunt_diag();
    send_byte(8'h7E); send_byte(8'h33);
    idle(2);
    clr_mon();
    send_byte(NODE); send_byte(8'h44); send_byte(8'h49);
    send_byte(8'h7E);
    idle(2);
    chk("R2 diag count", n_diag, 3);
    chk("R2 stays hunting", n_ok + n_bad + n_wr, 0);
    clr_mon();
    pl[0] = 8'hA0;
    send_frame(NODE, 1, 8'h00, 1'b1);
    idle(2);
    chk("R2 later frame ok", n_ok, 1);
  endtask

  task automatic t_csum();
    clr_mon();
    pl[0] = 8'h11;
    send_frame(NODE, 1, 8'h01, 1'b1);
    idle(2);
    chk("R5 bad strobe", n_bad, 1);
    chk("R5 no ok", n_ok, 0);
    clr_mon();
    send_byte(8'h7E); send_byte(NODE); send_byte(8'h7E);
    idle(2);
    chk("R5 addr-only bad", n_bad, 1);
  endtask

  task automatic t_escape();
    clr_mon();
    pl[0] = 8'h7E; pl[1] = 8'h7D; pl[2] = 8'h41;
    send_frame(NODE, 3, 8'h00, 1'b1);
    idle(2);
    chk("R6 ok", n_ok, 1);
    chk("R6 len", frame_len_o, 3);
    chk("R6 restored 7E", cap[0], 8'h7E);
    chk("R6 restored 7D", cap[1], 8'h7D);
    clr_mon();
    pl[0] = 8'h79;
    send_frame(NODE, 1, 8'h00, 1'b1);
    idle(2);
    chk("R6 escaped checksum ok", n_ok, 1);
    chk("R6 escaped checksum data", cap[0], 8'h79);
  endtask

  task automatic t_dangling();
    clr_mon();
    send_byte(8'h7E); send_byte(NODE); send_byte(NODE);
    send_byte(8'h7D); send_byte(8'h7E);
    idle(2);
    chk("R11 bad", n_bad, 1);
    chk("R11 no ok", n_ok, 0);
  endtask

  task automatic t_empty();
    clr_mon();
    for (int i = 0; i < 4; i++) send_byte(8'h7E);
    idle(2);
    chk("R7 silent", n_ok + n_bad + n_diag + n_ovr + n_ferr, 0);
    pl[0] = 8'h11;
    send_st(NODE); send_st(8'h11); send_st(8'h16); send_byte(8'h7E);
    idle(2);
    chk("R7 frame after preamble", n_ok, 1);
    chk("R7 no other strobe", n_bad + n_diag, 0);
  endtask

  task automatic t_resync();
    clr_mon();
    pl[0] = 8'h11; pl[1] = 8'h22;
    send_byte(8'h7E); send_byte(NODE); send_byte(8'h11); send_byte(8'h22);
    pl[0] = 8'hAA;
    send_frame(NODE, 1, 8'h00, 1'b1);
    idle(2);
    chk("R8 broken frame bad", n_bad, 1);
    chk("R8 next frame ok", n_ok, 1);
    chk("R8 len", frame_len_o, 1);
    chk("R8 data", cap[0], 8'hAA);
  endtask

  task automatic t_ovr();
    clr_mon();
    for (int i = 0; i < DEPTH; i++) pl[i] = 8'(i + 1);
    send_frame(NODE, DEPTH, 8'h00, 1'b1);
    idle(2);
    chk("R9 full frame ok", n_ok, 1);
    chk("R9 full len", frame_len_o, DEPTH);
    clr_mon();
    for (int i = 0; i < DEPTH + 1; i++) pl[i] = 8'(i + 1);
    send_frame(NODE, DEPTH + 1, 8'h00, 1'b1);
    idle(2);
    chk("R9 overrun strobe", n_ovr, 1);
    chk("R9 writes capped", n_wr, DEPTH);
    chk("R9 no ok", n_ok, 0);
  endtask

  task automatic t_ferr();
    clr_mon();
    send_byte(8'h7E); send_byte(NODE); send_byte(8'h11);
    send_byte(8'h22, 1'b1);
    send_byte(8'h16); send_byte(8'h7E);
    idle(2);
    chk("R10 ferr strobe", n_ferr, 1);
    chk("R10 aborted", n_ok + n_bad, 0);
    chk("R10 hunting", n_diag, 1);
    clr_mon();
    pl[0] = 8'h11;
    send_frame(NODE, 1, 8'h00, 1'b1);
    idle(2);
    chk("R10 recovers", n_ok, 1);
  endtask

  initial begin
    clr_mon();
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_good();
    t_mismatch();
    t_hunt_diag();
    t_csum();
    t_escape();
    t_dangling();
    t_empty();
    t_resync();
    t_ovr();
    t_ferr();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule